// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers the interrupt events of a data-converter peripheral into a single request line and a numeric vector. Six sources are tracked: a fresh result landing in the result register (ready), a result overwritten before it was read (result overflow), a new conversion request arriving while the previous one is still running (time overflow), and three window-comparator strobes (below, inside, above). Each source has a sticky pending flag and an enable bit. The vector names the most urgent source that is both pending and enabled, coded as an even number so software can use it directly as a jump-table offset.

The two overflow conditions are derived inside the block by two small state machines. The conversion tracker has states `CV_IDLE` and `CV_BUSY`: a conversion request moves `CV_IDLE`→`CV_BUSY` (start), a result load with no new request moves `CV_BUSY`→`CV_IDLE` (finish), and a request in `CV_BUSY` without a same-cycle result load is a time overflow (restart stays in `CV_BUSY`). The result tracker has states `RS_EMPTY` and `RS_UNREAD`: a result load moves `RS_EMPTY`→`RS_UNREAD` (fill), a result read with no load moves `RS_UNREAD`→`RS_EMPTY` (drain), and a load in `RS_UNREAD` without a same-cycle read is a result overflow (overwrite stays in `RS_UNREAD`).

Software services the block by reading the vector, which retires the reported source (except the ready source, retired only by reading the result or by an explicit clear), or by writing the vector, which retires everything.

Top module: `ivg_top`

## Requirements
- R1: After reset all pending flags and enable bits are zero, both trackers sit in their idle states, `irq` is 0 and `vec` is 0.
- R2: A `res_load` pulse sets the ready flag (bit 5); `res_read` or `rdy_clr` clears it; a vector read never clears it.
- R3: A `res_load` while the result tracker is in `RS_UNREAD`, without `res_read` in the same cycle, sets the result-overflow flag (bit 0).
- R4: A `conv_req` while the conversion tracker is in `CV_BUSY`, without `res_load` in the same cycle, sets the time-overflow flag (bit 1); a `conv_req` together with `res_load` restarts without overflow.
- R5: `cmp_hi`, `cmp_lo` and `cmp_in` set flag bits 2, 3 and 4 respectively.
- R6: A cycle with `en_we` high loads `en_wdata` into the enable register; enable bit n gates flag bit n.
- R7: `vec` is 0 when no flag is both pending and enabled; otherwise it is 2·(n+1) for the lowest such bit n, giving the order overflow(2), time overflow(4), high(6), low(8), in-window(10), ready(12).
- R8: A `vec_rd` cycle clears exactly the flag reported by `vec` in that cycle, unless it is the ready flag or `vec` is 0.
- R9: A `vec_wr` cycle clears all six flags.
- R10: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R11: `irq` equals `gie` ANDed with the OR of all enabled pending flags, in the same cycle as those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | New enable bits, bit n per flag n |
| res_load | input | 1 | A new result was loaded into the result register |
| res_read | input | 1 | The result register was read |
| conv_req | input | 1 | Sample-and-convert request |
| cmp_lo | input | 1 | Comparator: result below window |
| cmp_in | input | 1 | Comparator: result inside window |
| cmp_hi | input | 1 | Comparator: result above window |
| rdy_clr | input | 1 | Explicit clear of the ready flag |
| vec_rd | input | 1 | Vector register read strobe |
| vec_wr | input | 1 | Vector register write strobe |
| irq | output | 1 | Interrupt request |
| vec | output | 4 | Vector code of the top enabled pending source |

## Verification
Directed steps stack several sources and then read the vector repeatedly, which shows whether the priority order and the one-source-per-read retirement are right and whether ready survives reads. Back-to-back results with and without an intervening read, and back-to-back requests with and without a coinciding result, separate the overflow and no-overflow paths of both trackers. Coinciding set and clear strobes and enable rewrites that mask the top source tell set-wins and enable gating apart from plain flag state. A long seeded random run with sparse strobes, rare vector writes and a flickering global enable compares `vec` and `irq` every cycle against a reference model.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
    localparam int N_SRC   = 6;
    localparam int VEC_W   = 4;
    localparam int IDX_OVF = 0;
    localparam int IDX_TOV = 1;
    localparam int IDX_HI  = 2;
    localparam int IDX_LO  = 3;
    localparam int IDX_IN  = 4;
    localparam int IDX_RDY = 5;

    typedef enum logic {CV_IDLE, CV_BUSY}   conv_state_t;
    typedef enum logic {RS_EMPTY, RS_UNREAD} res_state_t;
endpackage

// File: rtl/ivg_event_track.sv
module ivg_event_track
    import ivg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_load,
    input  logic res_read,
    input  logic conv_req,
    output logic ovf_evt,
    output logic tov_evt
);
    conv_state_t conv_st, conv_nx;
    res_state_t  res_st,  res_nx;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_st <= CV_IDLE;
            res_st  <= RS_EMPTY;
        end else begin
            conv_st <= conv_nx;
            res_st  <= res_nx;
        end
    end

    // transitions and event outputs
    always_comb begin
        conv_nx = conv_st;
        tov_evt = 1'b0;
        unique case (conv_st)
            CV_IDLE: if (conv_req) conv_nx = CV_BUSY;
            CV_BUSY: begin
                if (conv_req && !res_load) tov_evt = 1'b1;
                if (res_load && !conv_req) conv_nx = CV_IDLE;
            end
            default: conv_nx = CV_IDLE;
        endcase

        res_nx  = res_st;
        ovf_evt = 1'b0;
        unique case (res_st)
            RS_EMPTY: if (res_load) res_nx = RS_UNREAD;
            RS_UNREAD: begin
                if (res_load && !res_read) ovf_evt = 1'b1;
                if (res_read && !res_load) res_nx = RS_EMPTY;
            end
            default: res_nx = RS_EMPTY;
        endcase
    end

    assert_busy_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> conv_st == CV_BUSY);
    assert_unread_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> res_st == RS_UNREAD);
    assert_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_read && !res_load) |=> res_st == RS_EMPTY);
endmodule

// File: rtl/ivg_flag_bank.sv
module ivg_flag_bank #(
    parameter int N      = 6,
    parameter int EXEMPT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] rd_clr,
    input  logic         clr_all,
    input  logic         ex_clr,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] en
);
    localparam logic [N-1:0] EX_MASK = {{(N-1){1'b0}}, 1'b1} << EXEMPT;

    logic [N-1:0] clr_vec;
    logic [N-1:0] flags_d;

    always_comb begin
        if (clr_all) clr_vec = '1;
        else         clr_vec = (rd_clr & ~EX_MASK) | (ex_clr ? EX_MASK : '0);
        flags_d = (flags & ~clr_vec) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            en    <= '0;
        end else begin
            flags <= flags_d;
            if (en_we) en <= en_wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chk
            assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[g] |=> flags[g]);
        end
    endgenerate

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && set_ev == '0) |=> flags == '0);
    assert_rdy_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[EXEMPT] && !clr_all && !ex_clr) |=> flags[EXEMPT]);
    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> en == $past(en_wdata));
endmodule

// File: rtl/ivg_prio_enc.sv
module ivg_prio_enc #(
    parameter int N  = 6,
    parameter int VW = 4
) (
    input  logic [N-1:0]  req,
    output logic [VW-1:0] vec,
    output logic [N-1:0]  top_oh
);
    logic [N-1:0] ahead;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_mask
            if (g == 0) begin : g_first
                assign ahead[g] = 1'b0;
            end else begin : g_rest
                assign ahead[g] = |req[g-1:0];
            end
            assign top_oh[g] = req[g] & ~ahead[g];
        end
    endgenerate

    always_comb begin
        vec = '0;
        for (int i = 0; i < N; i++) begin
            if (top_oh[i]) vec = vec | VW'(2 * (i + 1));
        end
    end
endmodule

// File: rtl/ivg_top.sv
module ivg_top
    import ivg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie,
    input  logic             en_we,
    input  logic [N_SRC-1:0] en_wdata,
    input  logic             res_load,
    input  logic             res_read,
    input  logic             conv_req,
    input  logic             cmp_lo,
    input  logic             cmp_in,
    input  logic             cmp_hi,
    input  logic             rdy_clr,
    input  logic             vec_rd,
    input  logic             vec_wr,
    output logic             irq,
    output logic [VEC_W-1:0] vec
);
    logic             ovf_evt, tov_evt;
    logic [N_SRC-1:0] set_ev, flags, en, pending, top_oh, rd_clr;

    ivg_event_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_load (res_load),
        .res_read (res_read),
        .conv_req (conv_req),
        .ovf_evt  (ovf_evt),
        .tov_evt  (tov_evt)
    );

    always_comb begin
        set_ev          = '0;
        set_ev[IDX_OVF] = ovf_evt;
        set_ev[IDX_TOV] = tov_evt;
        set_ev[IDX_HI]  = cmp_hi;
        set_ev[IDX_LO]  = cmp_lo;
        set_ev[IDX_IN]  = cmp_in;
        set_ev[IDX_RDY] = res_load;
        rd_clr          = vec_rd ? top_oh : '0;
    end

    ivg_flag_bank #(.N(N_SRC), .EXEMPT(IDX_RDY)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .rd_clr   (rd_clr),
        .clr_all  (vec_wr),
        .ex_clr   (res_read | rdy_clr),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .flags    (flags),
        .en       (en)
    );

    assign pending = flags & en;

    ivg_prio_enc #(.N(N_SRC), .VW(VEC_W)) u_enc (
        .req    (pending),
        .vec    (vec),
        .top_oh (top_oh)
    );

    assign irq = gie & (|pending);

    assert_irq_needs_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && vec != '0));
    assert_vec_zero_iff_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) == (pending == '0));
    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flags[IDX_OVF]);
    assert_tov_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tov_evt |=> flags[IDX_TOV]);
    assert_read_clears_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec == VEC_W'(2) && !res_load) |=> !flags[IDX_OVF]);
    assert_vec_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec[0] == 1'b0);
endmodule

// File: tb/test_ivg_top.sv
`timescale 1ns/1ps
module test_ivg_top;
    localparam int B_LOAD = 0, B_READ = 1, B_REQ = 2, B_LO = 3, B_IN = 4,
                   B_HI = 5, B_RCLR = 6, B_VRD = 7, B_VWR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gie = 1'b0, en_we = 1'b0;
    logic [5:0] en_wdata = '0;
    logic       res_load = 1'b0, res_read = 1'b0, conv_req = 1'b0;
    logic       cmp_lo = 1'b0, cmp_in = 1'b0, cmp_hi = 1'b0;
    logic       rdy_clr = 1'b0, vec_rd = 1'b0, vec_wr = 1'b0;
    logic       irq;
    logic [3:0] vec;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    logic [5:0] m_flags = '0, m_en = '0;
    logic       m_busy = 1'b0, m_unread = 1'b0;

    always #2.5 clk = ~clk;

    ivg_top i_ivg_top (
        .clk(clk), .rst_n(rst_n), .gie(gie), .en_we(en_we), .en_wdata(en_wdata),
        .res_load(res_load), .res_read(res_read), .conv_req(conv_req),
        .cmp_lo(cmp_lo), .cmp_in(cmp_in), .cmp_hi(cmp_hi), .rdy_clr(rdy_clr),
        .vec_rd(vec_rd), .vec_wr(vec_wr), .irq(irq), .vec(vec)
    );

    function automatic logic [3:0] prio_code(input logic [5:0] p);
        for (int i = 0; i < 6; i++) if (p[i]) return 4'(2 * (i + 1));
        return 4'd0;
    endfunction

    task automatic check(input string tag);
        logic [3:0] ev;
        logic       ei;
        ev = prio_code(m_flags & m_en);
        ei = gie & (|(m_flags & m_en));
        n_run++;
        if (vec !== ev || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: vec=%0d irq=%0b expected vec=%0d irq=%0b", tag, vec, irq, ev, ei);
        end
    endtask

    // drive one cycle of stimulus, advance the model, check after the edge
    task automatic cyc(input logic [8:0] st, input logic g, input logic we,
                       input logic [5:0] wd, input string tag);
        logic [3:0] code;
        logic [5:0] set, clr;
        logic       tov, ovf;
        res_load = st[B_LOAD]; res_read = st[B_READ]; conv_req = st[B_REQ];
        cmp_lo = st[B_LO]; cmp_in = st[B_IN]; cmp_hi = st[B_HI];
        rdy_clr = st[B_RCLR]; vec_rd = st[B_VRD]; vec_wr = st[B_VWR];
        gie = g; en_we = we; en_wdata = wd;
        code = prio_code(m_flags & m_en);
        tov  = st[B_REQ] && m_busy && !st[B_LOAD];
        ovf  = st[B_LOAD] && m_unread && !st[B_READ];
        set  = {st[B_LOAD], st[B_IN], st[B_LO], st[B_HI], tov, ovf};
        clr  = '0;
        if (st[B_VWR]) clr = '1;
        else begin
            if (st[B_VRD] && code != 0 && code != 12) clr[code/2 - 1] = 1'b1;
            if (st[B_READ] || st[B_RCLR]) clr[5] = 1'b1;
        end
        @(posedge clk);
        m_flags  = (m_flags & ~clr) | set;
        if (we) m_en = wd;
        m_busy   = st[B_REQ] ? 1'b1 : (st[B_LOAD] ? 1'b0 : m_busy);
        m_unread = st[B_LOAD] ? 1'b1 : (st[B_READ] ? 1'b0 : m_unread);
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [8:0] bit9(input int b);
        return 9'(1) << b;
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        gie = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        cyc('0, 1'b1, 1'b1, 6'h3F, "R6 enable all");
        cyc(bit9(B_LOAD), 1'b1, 1'b0, '0, "R2 ready set");
        cyc(bit9(B_VRD), 1'b1, 1'b0, '0, "R2 vector read keeps ready");
        cyc(bit9(B_LOAD), 1'b1, 1'b0, '0, "R3 overwrite unread result");
        cyc(bit9(B_HI), 1'b1, 1'b0, '0, "R5 high strobe");
        cyc(bit9(B_VRD), 1'b1, 1'b0, '0, "R8 read retires overflow");
        cyc(bit9(B_VRD), 1'b1, 1'b0, '0, "R8 read retires high");
        cyc(bit9(B_READ), 1'b1, 1'b0, '0, "R2 result read clears ready");
        cyc(bit9(B_LOAD) | bit9(B_READ), 1'b1, 1'b0, '0, "R3 load with read no overflow");
        cyc(bit9(B_RCLR) | bit9(B_READ), 1'b1, 1'b0, '0, "R2 explicit clear");
        cyc(bit9(B_REQ), 1'b1, 1'b0, '0, "R4 start conversion");
        cyc(bit9(B_REQ), 1'b1, 1'b0, '0, "R4 request while busy");
        cyc(bit9(B_REQ) | bit9(B_LOAD), 1'b1, 1'b0, '0, "R4 restart with result");
        cyc(bit9(B_LO) | bit9(B_IN), 1'b1, 1'b0, '0, "R5 low and inside strobes");
        cyc('0, 1'b1, 1'b1, 6'h3D, "R6 R7 mask time overflow");
        cyc('0, 1'b1, 1'b1, 6'h30, "R7 only inside and ready enabled");
        cyc('0, 1'b0, 1'b0, '0, "R11 global enable off");
        cyc(bit9(B_VWR) | bit9(B_IN), 1'b1, 1'b0, '0, "R10 set wins over write clear");
        cyc(bit9(B_VWR), 1'b1, 1'b1, 6'h3F, "R9 write clears all");
        cyc(bit9(B_LOAD) | bit9(B_RCLR), 1'b1, 1'b0, '0, "R10 set wins over ready clear");
        cyc(bit9(B_VWR), 1'b1, 1'b0, '0, "R9 write clears all again");

        for (int k = 0; k < 4000; k++) begin
            logic [8:0] st;
            logic       g, we;
            for (int b = 0; b < 8; b++) st[b] = ($urandom % 4) == 0;
            st[B_VWR] = ($urandom % 40) == 0;
            g  = ($urandom % 8) != 0;
            we = ($urandom % 16) == 0;
            cyc(st, g, we, 6'($urandom), "R7 R11 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule